// File: doc/BRIEF.md
# Page-Buffered Byte-Wide Nonvolatile Write Controller

This block models the write path of a byte-wide nonvolatile memory that a host drives like a static RAM. The host uses an address, a data input, a data output and three active-low strobes: chip enable, output enable and write enable. All of them are sampled on the system clock. A write pulse loads one byte into a page buffer. Further loads into the same page keep the load window open. When the host stops loading for a set number of clock cycles, the window closes and a timed programming phase begins. At the end of that phase, only the bytes that were loaded are copied into the storage array.

While programming runs, a read returns a status byte instead of array data. Its top bit is the inverse of the top bit of the last byte loaded, and bit 6 alternates from one read to the next. The host can therefore poll either bit to find out when the write has finished. The storage is a small register array that holds the erased value 0xFF after reset.

Top module: `eeprom_page_writer`

## Requirements
- R1: After reset, busy is low and every array location reads 0xFF.
- R2: A write strobe is active only while chip enable and write enable are both low and output enable is high. Either enable may be the one that falls second. With output enable low, no byte is loaded and no load window opens.
- R3: The address is taken in the first cycle the write strobe becomes active. The data is the value present in the last active cycle before the strobe ends.
- R4: Address bits [6:0] select the byte within a 128-byte page, and the bits above them select the page. The first load fixes the page for the window. A later load to another page is dropped and leaves that page unchanged.
- R5: Bytes may be loaded in any order. Loading the same offset again within a window replaces the earlier value.
- R6: The window closes once GAP_CYCLES cycles pass with no strobe activity after a load. Busy then rises one cycle later, on the (GAP_CYCLES+1)-th cycle after the strobe ends, and stays high for exactly PROG_CYCLES cycles. It never rises while a write strobe is active.
- R7: Programming writes only the loaded offsets. All other bytes of the page keep their contents.
- R8: A read while busy returns bit 7 as the complement of bit 7 of the last loaded byte, and bits [5:0] equal to that byte's bits [5:0].
- R9: While busy, bit 6 reads 0 on the first read, flips after each completed read access, and holds steady within an access. After busy falls, reads return array data.
- R10: Write strobes that start while busy load nothing.
- R11: dout_en is high exactly when chip enable and output enable are low and write enable is high. dout is 0 whenever dout_en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Byte address (page in the upper bits, offset in [6:0]) |
| din | input | DATA_W | Write data |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| dout | output | DATA_W | Read data or status byte |
| dout_en | output | 1 | Read data valid (output drive enable) |
| busy | output | 1 | Programming in progress |

## Verification
Two events can fall in the same cycle: a read access ends while the programming counter reaches its last count. The toggle flip and the commit then coincide, and the access that follows must see true data, not a flipped status bit. The bench provokes this by polling back to back, in single-cycle read accesses, through the whole busy phase. The bench also issues a write during busy. A reference model that steps every clock judges each cycle's dout, dout_en and busy.

// File: rtl/eepw_pkg.sv
package eepw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_PROG = 2'd2
  } ctl_state_e;
endpackage

// File: rtl/eepw_host_if.sv
// Strobe decode, address capture on strobe start, data capture through
// the strobe, and detection of load and read completion.
module eepw_host_if #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  input  logic              block,
  output logic              stb_active,
  output logic              rd_active,
  output logic              load_pulse,
  output logic              rd_done,
  output logic [ADDR_W-1:0] load_addr,
  output logic [DATA_W-1:0] load_data
);
  logic              stb_q, rd_q, arm_q, arm_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              stb_start;

  assign stb_active = ~ce_n & ~we_n & oe_n;
  assign rd_active  = ~ce_n & ~oe_n & we_n;
  assign stb_start  = stb_active & ~stb_q;

  always_comb begin
    addr_d = addr_q;
    arm_d  = arm_q;
    data_d = data_q;
    if (stb_start) begin
      addr_d = addr;
      arm_d  = ~block;
    end
    if (stb_active) data_d = din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_q  <= 1'b0;
      rd_q   <= 1'b0;
      arm_q  <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      stb_q  <= stb_active;
      rd_q   <= rd_active;
      arm_q  <= arm_d;
      addr_q <= addr_d;
      data_q <= data_d;
    end
  end

  assign load_pulse = stb_q & ~stb_active & arm_q;
  assign rd_done    = rd_q & ~rd_active;
  assign load_addr  = addr_q;
  assign load_data  = data_q;
endmodule

// File: rtl/eepw_page_buf.sv
// Page register with a per-byte loaded flag.
module eepw_page_buf #(
  parameter int OFF_W  = 7,
  parameter int DATA_W = 8,
  localparam int PB    = 1 << OFF_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clear,
  input  logic                 wr,
  input  logic [OFF_W-1:0]     wr_off,
  input  logic [DATA_W-1:0]    wr_data,
  output logic [PB*DATA_W-1:0] buf_flat,
  output logic [PB-1:0]        valid
);
  for (genvar g = 0; g < PB; g++) begin : g_byte
    logic hit;
    assign hit = wr & (wr_off == OFF_W'(g));

    always_ff @(posedge clk) begin
      if (hit) buf_flat[g*DATA_W +: DATA_W] <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     valid[g] <= 1'b0;
      else if (clear) valid[g] <= 1'b0;
      else if (hit)   valid[g] <= 1'b1;
    end
  end
endmodule

// File: rtl/eepw_array.sv
// Storage array: erased on reset, commits flagged page bytes in one cycle.
module eepw_array #(
  parameter int ADDR_W = 10,
  parameter int OFF_W  = 7,
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] ERASED = '1,
  localparam int PB    = 1 << OFF_W,
  localparam int DEPTH = 1 << ADDR_W,
  localparam int PG_W  = ADDR_W - OFF_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 commit,
  input  logic [PG_W-1:0]      commit_page,
  input  logic [PB*DATA_W-1:0] buf_flat,
  input  logic [PB-1:0]        valid,
  input  logic [ADDR_W-1:0]    rd_addr,
  output logic [DATA_W-1:0]    rd_data
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= ERASED;
    end else if (commit) begin
      for (int o = 0; o < PB; o++) begin
        if (valid[o]) mem[{commit_page, OFF_W'(o)}] <= buf_flat[o*DATA_W +: DATA_W];
      end
    end
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer #(
  parameter int ADDR_W      = 10,
  parameter int DATA_W      = 8,
  parameter int OFF_W       = 7,
  parameter int GAP_CYCLES  = 40,
  parameter int PROG_CYCLES = 60
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en,
  output logic              busy
);
  import eepw_pkg::*;

  localparam int PB     = 1 << OFF_W;
  localparam int PG_W   = ADDR_W - OFF_W;
  localparam int GAP_W  = $clog2(GAP_CYCLES + 1);
  localparam int PROG_W = $clog2(PROG_CYCLES + 1);
  localparam logic [GAP_W-1:0]  GAP_LAST  = GAP_W'(GAP_CYCLES - 1);
  localparam logic [PROG_W-1:0] PROG_LAST = PROG_W'(PROG_CYCLES - 1);
  localparam int TOG_BIT = DATA_W - 2;

  ctl_state_e          state_q, state_d;
  logic [GAP_W-1:0]    gap_q, gap_d;
  logic [PROG_W-1:0]   pc_q, pc_d;
  logic [PG_W-1:0]     page_q, page_d;
  logic [DATA_W-1:0]   poll_q, poll_d;

  logic                stb_active, rd_active, load_pulse, rd_done;
  logic [ADDR_W-1:0]   load_addr;
  logic [DATA_W-1:0]   load_data, rd_data;
  logic                buf_wr, commit;
  logic [PB*DATA_W-1:0] buf_flat;
  logic [PB-1:0]       valid;
  logic                page_match;

  eepw_host_if #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) host_i (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .din(din), .block(busy),
    .stb_active(stb_active), .rd_active(rd_active),
    .load_pulse(load_pulse), .rd_done(rd_done),
    .load_addr(load_addr), .load_data(load_data)
  );

  eepw_page_buf #(.OFF_W(OFF_W), .DATA_W(DATA_W)) pbuf_i (
    .clk(clk), .rst_n(rst_n), .clear(commit), .wr(buf_wr),
    .wr_off(load_addr[OFF_W-1:0]), .wr_data(load_data),
    .buf_flat(buf_flat), .valid(valid)
  );

  eepw_array #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .DATA_W(DATA_W)) arr_i (
    .clk(clk), .rst_n(rst_n), .commit(commit), .commit_page(page_q),
    .buf_flat(buf_flat), .valid(valid), .rd_addr(addr), .rd_data(rd_data)
  );

  assign page_match = (load_addr[ADDR_W-1:OFF_W] == page_q);

  // Next-state logic
  always_comb begin
    state_d = state_q;
    gap_d   = gap_q;
    pc_d    = pc_q;
    page_d  = page_q;
    poll_d  = poll_q;
    buf_wr  = 1'b0;
    commit  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (load_pulse) begin
          buf_wr  = 1'b1;
          page_d  = load_addr[ADDR_W-1:OFF_W];
          poll_d  = load_data ^ {1'b1, {(DATA_W-1){1'b0}}};
          poll_d[TOG_BIT] = 1'b0;
          gap_d   = '0;
          state_d = ST_LOAD;
        end
      end
      ST_LOAD: begin
        if (load_pulse && page_match) begin
          buf_wr = 1'b1;
          poll_d = load_data ^ {1'b1, {(DATA_W-1){1'b0}}};
          poll_d[TOG_BIT] = 1'b0;
          gap_d  = '0;
        end else if (stb_active) begin
          gap_d = '0;
        end else if (gap_q == GAP_LAST) begin
          state_d = ST_PROG;
          pc_d    = '0;
          poll_d[TOG_BIT] = 1'b0;
        end else begin
          gap_d = gap_q + 1'b1;
        end
      end
      ST_PROG: begin
        if (rd_done) poll_d[TOG_BIT] = ~poll_q[TOG_BIT];
        if (pc_q == PROG_LAST) begin
          commit  = 1'b1;
          state_d = ST_IDLE;
        end else begin
          pc_d = pc_q + 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      gap_q   <= '0;
      pc_q    <= '0;
      page_q  <= '0;
      poll_q  <= '0;
    end else begin
      state_q <= state_d;
      gap_q   <= gap_d;
      pc_q    <= pc_d;
      page_q  <= page_d;
      poll_q  <= poll_d;
    end
  end

  assign busy    = (state_q == ST_PROG);
  assign dout_en = rd_active;
  assign dout    = !rd_active ? '0 : (busy ? poll_q : rd_data);
endmodule

// File: rtl/eepw_checker.sv
module eepw_checker #(
  parameter int DATA_W      = 8,
  parameter int PROG_CYCLES = 60
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ce_n,
  input logic              oe_n,
  input logic              we_n,
  input logic [DATA_W-1:0] dout,
  input logic              dout_en,
  input logic              busy
);
  logic [31:0] busy_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_len <= '0;
    else if (busy) busy_len <= busy_len + 1'b1;
    else           busy_len <= '0;
  end

  AST_QUIET_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_en |-> (dout == '0)); // R11

  AST_NO_CLOSE_IN_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(!(!ce_n && !we_n && oe_n))); // R6

  AST_PROG_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busy_len == PROG_CYCLES)); // R6

  AST_POLL_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && dout_en && $past(dout_en)) |-> $stable(dout)); // R9

  AST_READ_NEEDS_WE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> !dout_en); // R11
endmodule

bind eeprom_page_writer eepw_checker #(.DATA_W(DATA_W), .PROG_CYCLES(PROG_CYCLES)) chk_i (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
  .dout(dout), .dout_en(dout_en), .busy(busy)
);

// File: tb/eeprom_page_writer_tb_top.sv
`timescale 1ns/1ps
module eeprom_page_writer_tb_top;
  localparam int AW = 10;
  localparam int GAP = 40;
  localparam int PROG = 60;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] addr;
  logic [7:0]    din;
  logic          ce_n, oe_n, we_n;
  logic [7:0]    dout;
  logic          dout_en, busy;

  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  eeprom_page_writer #(.ADDR_W(AW), .DATA_W(8), .OFF_W(7),
                       .GAP_CYCLES(GAP), .PROG_CYCLES(PROG)) dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .din(din), .ce_n(ce_n),
    .oe_n(oe_n), .we_n(we_n), .dout(dout), .dout_en(dout_en), .busy(busy)
  );

  // ---------------- behavioural reference model ----------------
  logic [7:0] m_mem [1024];
  logic [7:0] m_buf [128];
  bit         m_val [128];
  int         m_mode, m_gap, m_pc, m_page, m_acap;
  logic [7:0] m_dcap, m_last;
  bit         m_tog, m_pstb, m_prd, m_arm;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_mem[i]) m_mem[i] = 8'hFF;
      foreach (m_val[i]) m_val[i] = 0;
      m_mode = 0; m_gap = 0; m_pc = 0; m_page = 0; m_acap = 0;
      m_dcap = 0; m_last = 0; m_tog = 0; m_pstb = 0; m_prd = 0; m_arm = 0;
    end else begin
      bit stb, rd, ld, rdone;
      int old_mode;
      stb = !ce_n && !we_n && oe_n;
      rd  = !ce_n && !oe_n && we_n;
      ld  = m_pstb && !stb && m_arm;
      rdone = m_prd && !rd;
      old_mode = m_mode;
      if (m_mode == 0) begin
        if (ld) begin
          m_buf[m_acap % 128] = m_dcap; m_val[m_acap % 128] = 1;
          m_page = m_acap / 128; m_last = m_dcap; m_gap = 0; m_mode = 1;
        end
      end else if (m_mode == 1) begin
        if (ld && (m_acap / 128) == m_page) begin
          m_buf[m_acap % 128] = m_dcap; m_val[m_acap % 128] = 1;
          m_last = m_dcap; m_gap = 0;
        end else if (stb) m_gap = 0;
        else if (m_gap == GAP - 1) begin
          m_mode = 2; m_pc = 0; m_tog = 0;
        end else m_gap++;
      end else begin
        if (rdone) m_tog = !m_tog;
        if (m_pc == PROG - 1) begin
          for (int o = 0; o < 128; o++) begin
            if (m_val[o]) m_mem[m_page * 128 + o] = m_buf[o];
            m_val[o] = 0;
          end
          m_mode = 0;
        end else m_pc++;
      end
      if (stb && !m_pstb) begin
        m_acap = int'(addr);
        m_arm  = (old_mode != 2);
      end
      if (stb) m_dcap = din;
      m_pstb = stb;
      m_prd  = rd;
    end
  end

  task automatic chk(string tag, int got, int exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", tag, got, exp, $time);
    end
  endtask

  // Cycle compare against the model, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      bit rd;
      logic [7:0] exp_d;
      rd = !ce_n && !oe_n && we_n;
      if (!rd) exp_d = 8'h00;
      else if (m_mode == 2) exp_d = {~m_last[7], m_tog, m_last[5:0]};
      else exp_d = m_mem[addr];
      chk("R11 dout_en", int'(dout_en), int'(rd));
      chk("R6 busy", int'(busy), int'(m_mode == 2));
      chk(m_mode == 2 ? "R8 status byte" : "R7 read data", int'(dout), int'(exp_d));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
      ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [7:0] d);
    @(negedge clk); #1;
    addr = a; din = d; oe_n = 1'b1; ce_n = 1'b0; we_n = 1'b0;
    @(negedge clk); #1;
    @(negedge clk); #1;
    ce_n = 1'b1; we_n = 1'b1;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [7:0] v);
    @(negedge clk); #1;
    addr = a; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
    @(negedge clk);
    v = dout;
    #1; ce_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic wait_busy_edge(bit lvl, output int n);
    n = 0;
    while (busy !== lvl && n < 500) begin
      @(negedge clk); n++;
    end
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int n;
    rst_n = 1'b0; addr = '0; din = '0; ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    idle(2);

    // R1 reset state
    chk("R1 busy after reset", int'(busy), 0);
    rd(10'h005, v); chk("R1 erased read", int'(v), 8'hFF);
    rd(10'h3FF, v); chk("R1 erased read top", int'(v), 8'hFF);
    @(negedge clk); chk("R11 dout idle", int'(dout), 0);

    // R2 strobe with OE low loads nothing
    @(negedge clk); #1;
    addr = 10'h040; din = 8'h12; ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b0;
    @(negedge clk); chk("R11 no drive with WE low", int'(dout_en), 0);
    #1; ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    idle(GAP + 10);
    chk("R2 OE-low strobe opens no window", int'(busy), 0);

    // R2/R3: WE falls first, CE falls last; addr and data change mid-strobe
    @(negedge clk); #1;
    addr = 10'h333; din = 8'h99; oe_n = 1'b1; we_n = 1'b0;
    @(negedge clk); #1; addr = 10'h010; din = 8'h11; ce_n = 1'b0;
    @(negedge clk); #1; addr = 10'h020; din = 8'h22;
    @(negedge clk); #1; ce_n = 1'b1; we_n = 1'b1;
    wait_busy_edge(1'b1, n);
    chk("R6 window close latency", n, GAP + 1);
    wait_busy_edge(1'b0, n);
    chk("R6 busy length", n, PROG);
    idle(1);
    rd(10'h010, v); chk("R3 address at strobe start, data at end", int'(v), 8'h22);
    rd(10'h020, v); chk("R3 later address not used", int'(v), 8'hFF);
    rd(10'h333, v); chk("R2 CE high keeps strobe inactive", int'(v), 8'hFF);

    // R4/R5 page loads in any order, overwrite, wrong page dropped
    wr(10'h105, 8'h3C);
    wr(10'h101, 8'hA5);
    wr(10'h105, 8'h5A);
    wr(10'h181, 8'h77);
    wait_busy_edge(1'b1, n);
    // R8/R9: last loaded byte is 0x5A, so status reads 0x9A then 0xDA
    rd(10'h000, v); chk("R8 first poll", int'(v), 8'h9A);
    rd(10'h105, v); chk("R9 second poll flips bit 6", int'(v), 8'hDA);
    rd(10'h105, v); chk("R9 third poll", int'(v), 8'h9A);
    // R10 write during busy
    wr(10'h102, 8'h11);
    wait_busy_edge(1'b0, n);
    idle(1);
    rd(10'h105, v); chk("R5 overwrite within window", int'(v), 8'h5A);
    rd(10'h101, v); chk("R5 out-of-order load", int'(v), 8'hA5);
    rd(10'h102, v); chk("R10 write while busy dropped", int'(v), 8'hFF);
    rd(10'h104, v); chk("R7 unloaded byte untouched", int'(v), 8'hFF);
    rd(10'h181, v); chk("R4 other page dropped", int'(v), 8'hFF);

    // R7 rewrite one byte; neighbour keeps earlier value
    wr(10'h101, 8'h81);
    wait_busy_edge(1'b1, n);
    rd(10'h101, v); chk("R8 poll of 0x81", int'(v), 8'h01);
    // back-to-back single-cycle reads across the end of programming (R9)
    while (busy) begin
      @(negedge clk); #1; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; addr = 10'h101;
      @(negedge clk); #1; ce_n = 1'b1; oe_n = 1'b1;
    end
    rd(10'h101, v); chk("R9 true data after busy", int'(v), 8'h81);
    rd(10'h105, v); chk("R7 neighbour kept", int'(v), 8'h5A);

    idle(3);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule